// File: doc/BRIEF.md
# Parallel-port peripheral register interface

This block is the device end of an enhanced parallel port link. The host shares one 8-bit bus for addresses and data. An address strobe cycle loads a selector byte. Each later data strobe cycle reads or writes the register that the selector points at. The block answers every strobe with a wait handshake. That wait line rises once the strobe has been seen inside the clock domain, and it falls again once the strobe has been withdrawn.

The registers behind the selector fall into three groups. A bank of byte-wide timer preset registers feeds a PWM counter stage. A sticky latch records the fault lines of a power module. A decoder drives eight on/off load outputs, arranged as two groups of four. The block also passes an interrupt request through to the host. A host-driven active-low init line clears the whole register state.

All strobe and init inputs are asynchronous. Each passes through a two-flop synchronizer before any edge logic sees it. The host is expected to hold the bus and the write line stable while a strobe is low.

Top module: `epp_periph`

## Requirements
- R1: A low level on `addr_stb_n` loads `ad_in` into the selector. The selector keeps that value for any number of following data cycles, until the next address cycle.
- R2: `wait_o` rises on the third rising clock edge after a strobe falls. It falls on the third rising clock edge after that strobe rises again.
- R3: Selector values 0x00 to 0x03 select four timer preset registers. A write stores `ad_in` and a read returns the stored byte. Register k appears on `tmr_val[8k+7:8k]`.
- R4: Selector value 0x20+k, for k from 0 to 7, addresses load k alone. A write sets `loads[k]` to data bit 0. A read returns 0x00 or 0x01, following the state of that load.
- R5: A write to selector 0x28 sets `loads[3:0]` from data bits 3..0. A write to 0x29 sets `loads[7:4]` from data bits 3..0. A read of either returns the group's four bits in bits 3..0, with the upper bits zero.
- R6: A high bit on `fault_in` sets the matching latch bit at the next clock edge, and the bit stays set. A read of selector 0x10 returns the latch in bits 3..0. A write to 0x10 clears each latch bit whose data bit is 1. When a fault input is still high, its bit stays set even through such a clear.
- R7: `ad_oe` is high only while `data_stb_n` is low and `write_n` is high. On a read, `ad_out` holds the selected value by the time `wait_o` rises.
- R8: A write to any selector value not listed above changes no output and no register. A read of such a value returns 0x00.
- R9: Holding `init_n` low clears the timer registers, the loads, the fault latch and the selector by the third rising clock edge. The same state is cleared by `rst`.
- R10: `irq_o` follows `irq_in` one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_in | input | 8 | Shared address/data bus, input side |
| ad_out | output | 8 | Read data for the shared bus |
| ad_oe | output | 1 | Bus driver enable for read cycles |
| addr_stb_n | input | 1 | Address strobe, active low |
| data_stb_n | input | 1 | Data strobe, active low |
| write_n | input | 1 | Low for a host write, high for a host read |
| init_n | input | 1 | Host peripheral reset, active low |
| wait_o | output | 1 | Handshake answer to the host |
| irq_in | input | 1 | Interrupt source |
| irq_o | output | 1 | Interrupt request to the host |
| fault_in | input | 4 | Power module fault lines, active high, synchronous to clk |
| tmr_val | output | 32 | Timer preset registers, register k in bits 8k+7..8k |
| loads | output | 8 | On/off load outputs, two groups of four |

## Verification
The hardest case to reach is a fault input that stays high while the host writes the clear mask. A set and a clear of the same latch bit then fall on one clock edge. The bench holds one fault line high across a full clear cycle and reads the latch back afterwards. It then releases the line and clears again, so the two outcomes can be compared. Selector persistence is also hard to see directly. The bench makes several data reads after a single address cycle. It also reads the bus back right after an init pulse, without writing a new address first.

// File: rtl/epp_periph_pkg.sv
`timescale 1ns/1ps
package epp_periph_pkg;
    typedef logic [7:0] byte_t;
    typedef logic [3:0] idx_t;

    typedef enum logic [1:0] {HS_IDLE, HS_ADDR, HS_DATA} hs_state_e;

    typedef struct packed {
        logic addr_cap;
        logic data_wr;
        logic data_rd;
    } hs_cmd_t;

    typedef enum logic [2:0] {T_NONE, T_TMR, T_FAULT, T_LBIT, T_LGRP} tgt_e;

    typedef struct packed {
        tgt_e kind;
        idx_t idx;
    } sel_t;

    localparam byte_t TMR_BASE    = 8'h00;
    localparam byte_t FAULT_ADDR  = 8'h10;
    localparam byte_t LBIT_BASE   = 8'h20;
    localparam byte_t LGRP_BASE   = 8'h28;

    function automatic sel_t decode_sel(byte_t a, int ntmr, int nload, int ngrp);
        sel_t s;
        int off_t;
        int off_b;
        int off_g;
        s.kind = T_NONE;
        s.idx  = '0;
        off_t  = int'(a) - int'(TMR_BASE);
        off_b  = int'(a) - int'(LBIT_BASE);
        off_g  = int'(a) - int'(LGRP_BASE);
        if (off_t >= 0 && off_t < ntmr) begin
            s.kind = T_TMR;
            s.idx  = off_t[3:0];
        end else if (a == FAULT_ADDR) begin
            s.kind = T_FAULT;
        end else if (off_b >= 0 && off_b < nload) begin
            s.kind = T_LBIT;
            s.idx  = off_b[3:0];
        end else if (off_g >= 0 && off_g < ngrp) begin
            s.kind = T_LGRP;
            s.idx  = off_g[3:0];
        end
        return s;
    endfunction
endpackage

// File: rtl/epp_periph_sync.sv
`timescale 1ns/1ps
module epp_periph_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/epp_periph_hs.sv
`timescale 1ns/1ps
module epp_periph_hs
    import epp_periph_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    astb_s,
    input  logic    dstb_s,
    input  logic    write_n,
    output hs_cmd_t cmd,
    output logic    wait_o
);
    hs_state_e st, st_n;
    logic go_data;

    assign cmd.addr_cap = (st == HS_IDLE) && !astb_s;
    assign go_data      = (st == HS_IDLE) && astb_s && !dstb_s;
    assign cmd.data_wr  = go_data && !write_n;
    assign cmd.data_rd  = go_data && write_n;
    assign wait_o       = (st != HS_IDLE);

    always_comb begin
        st_n = st;
        unique case (st)
            HS_IDLE: begin
                if (cmd.addr_cap)  st_n = HS_ADDR;
                else if (go_data)  st_n = HS_DATA;
            end
            HS_ADDR: if (astb_s) st_n = HS_IDLE;
            HS_DATA: if (dstb_s) st_n = HS_IDLE;
            default: st_n = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= HS_IDLE;
        else     st <= st_n;
    end
endmodule

// File: rtl/epp_periph_regs.sv
`timescale 1ns/1ps
module epp_periph_regs
    import epp_periph_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int NUM_FAULT = 4,
    parameter int GRP_SIZE  = 4,
    parameter int NUM_GRP   = 2,
    localparam int NUM_LOADS = GRP_SIZE * NUM_GRP
) (
    input  logic                   clk,
    input  logic                   rst,
    input  hs_cmd_t                cmd,
    input  byte_t                  ad_in,
    input  logic [NUM_FAULT-1:0]   fault_in,
    output logic [NUM_TMR*8-1:0]   tmr_val,
    output logic [NUM_LOADS-1:0]   loads,
    output byte_t                  rd_q
);
    byte_t                addr_q;
    sel_t                 sel;
    byte_t                tmr_q [NUM_TMR];
    logic [NUM_FAULT-1:0] fault_q;
    logic [NUM_FAULT-1:0] clr_mask;
    byte_t                rd_d;

    assign sel = decode_sel(addr_q, NUM_TMR, NUM_LOADS, NUM_GRP);

    always_ff @(posedge clk) begin
        if (rst)               addr_q <= '0;
        else if (cmd.addr_cap) addr_q <= ad_in;
    end

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
        always_ff @(posedge clk) begin
            if (rst)
                tmr_q[k] <= '0;
            else if (cmd.data_wr && sel.kind == T_TMR && sel.idx == idx_t'(k))
                tmr_q[k] <= ad_in;
        end
        assign tmr_val[k*8 +: 8] = tmr_q[k];
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        for (genvar b = 0; b < GRP_SIZE; b++) begin : g_bit
            localparam int LI = g * GRP_SIZE + b;
            always_ff @(posedge clk) begin
                if (rst)
                    loads[LI] <= 1'b0;
                else if (cmd.data_wr && sel.kind == T_LBIT && sel.idx == idx_t'(LI))
                    loads[LI] <= ad_in[0];
                else if (cmd.data_wr && sel.kind == T_LGRP && sel.idx == idx_t'(g))
                    loads[LI] <= ad_in[b];
            end
        end
    end

    assign clr_mask = (cmd.data_wr && sel.kind == T_FAULT) ? ad_in[NUM_FAULT-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) fault_q <= '0;
        else     fault_q <= (fault_q & ~clr_mask) | fault_in;
    end

    always_comb begin
        rd_d = '0;
        unique case (sel.kind)
            T_TMR: begin
                for (int k = 0; k < NUM_TMR; k++)
                    if (sel.idx == k[3:0]) rd_d = tmr_q[k];
            end
            T_FAULT: rd_d[NUM_FAULT-1:0] = fault_q;
            T_LBIT: begin
                for (int k = 0; k < NUM_LOADS; k++)
                    if (sel.idx == k[3:0]) rd_d[0] = loads[k];
            end
            T_LGRP: begin
                for (int g = 0; g < NUM_GRP; g++)
                    if (sel.idx == g[3:0]) rd_d[GRP_SIZE-1:0] = loads[g*GRP_SIZE +: GRP_SIZE];
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)              rd_q <= '0;
        else if (cmd.data_rd) rd_q <= rd_d;
    end
endmodule

// File: rtl/epp_periph.sv
`timescale 1ns/1ps
module epp_periph
    import epp_periph_pkg::*;
#(
    parameter int NUM_TMR   = 4,
    parameter int NUM_FAULT = 4,
    parameter int GRP_SIZE  = 4,
    parameter int NUM_GRP   = 2,
    localparam int NUM_LOADS = GRP_SIZE * NUM_GRP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [7:0]            ad_in,
    output logic [7:0]            ad_out,
    output logic                  ad_oe,
    input  logic                  addr_stb_n,
    input  logic                  data_stb_n,
    input  logic                  write_n,
    input  logic                  init_n,
    output logic                  wait_o,
    input  logic                  irq_in,
    output logic                  irq_o,
    input  logic [NUM_FAULT-1:0]  fault_in,
    output logic [NUM_TMR*8-1:0]  tmr_val,
    output logic [NUM_LOADS-1:0]  loads
);
    logic [2:0] sync_q;
    logic       init_s;
    logic       astb_s;
    logic       dstb_s;
    logic       rst_i;
    hs_cmd_t    cmd;
    byte_t      rd_q;

    epp_periph_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({init_n, addr_stb_n, data_stb_n}),
        .q   (sync_q)
    );

    assign init_s = sync_q[2];
    assign astb_s = sync_q[1];
    assign dstb_s = sync_q[0];
    assign rst_i  = rst | ~init_s;

    epp_periph_hs u_hs (
        .clk     (clk),
        .rst     (rst_i),
        .astb_s  (astb_s),
        .dstb_s  (dstb_s),
        .write_n (write_n),
        .cmd     (cmd),
        .wait_o  (wait_o)
    );

    epp_periph_regs #(
        .NUM_TMR   (NUM_TMR),
        .NUM_FAULT (NUM_FAULT),
        .GRP_SIZE  (GRP_SIZE),
        .NUM_GRP   (NUM_GRP)
    ) u_regs (
        .clk      (clk),
        .rst      (rst_i),
        .cmd      (cmd),
        .ad_in    (ad_in),
        .fault_in (fault_in),
        .tmr_val  (tmr_val),
        .loads    (loads),
        .rd_q     (rd_q)
    );

    assign ad_out = rd_q;
    assign ad_oe  = ~data_stb_n & write_n;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= irq_in;
    end
endmodule

// File: rtl/epp_periph_chk.sv
`timescale 1ns/1ps
module epp_periph_chk #(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LOADS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 astb_s,
    input logic                 dstb_s,
    input logic                 init_s,
    input logic                 wait_o,
    input logic                 write_n,
    input logic                 data_stb_n,
    input logic                 ad_oe,
    input logic                 irq_in,
    input logic                 irq_o,
    input logic [NUM_TMR*8-1:0] tmr_val,
    input logic [NUM_LOADS-1:0] loads
);
    p_wait_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_o) |-> $past(!astb_s || !dstb_s));

    p_wait_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_o) |-> ($past(astb_s && dstb_s) || $past(!init_s)));

    p_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (!write_n || data_stb_n) |-> !ad_oe);

    p_load_change_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(loads) |-> ($rose(wait_o) || $past(!init_s)));

    p_tmr_change_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(tmr_val) |-> ($rose(wait_o) || $past(!init_s)));

    p_init_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !init_s |=> (loads == '0 && tmr_val == '0));

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(irq_in)));
endmodule

bind epp_periph epp_periph_chk #(
    .NUM_TMR   (NUM_TMR),
    .NUM_LOADS (NUM_LOADS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .astb_s     (astb_s),
    .dstb_s     (dstb_s),
    .init_s     (init_s),
    .wait_o     (wait_o),
    .write_n    (write_n),
    .data_stb_n (data_stb_n),
    .ad_oe      (ad_oe),
    .irq_in     (irq_in),
    .irq_o      (irq_o),
    .tmr_val    (tmr_val),
    .loads      (loads)
);

// File: tb/epp_periph_test.sv
`timescale 1ns/1ps
module epp_periph_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic        addr_stb_n = 1'b1;
    logic        data_stb_n = 1'b1;
    logic        write_n = 1'b1;
    logic        init_n = 1'b1;
    logic        wait_o;
    logic        irq_in = 1'b0;
    logic        irq_o;
    logic [3:0]  fault_in = 4'h0;
    logic [31:0] tmr_val;
    logic [7:0]  loads;

    int checks = 0;
    int errors = 0;
    logic cmp_en = 1'b0;

    logic [7:0] m_tmr [NT];
    logic [7:0] m_loads = 8'h00;
    logic [7:0] m_addr = 8'h00;

    epp_periph uut (
        .clk(clk), .rst(rst), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .write_n(write_n),
        .init_n(init_n), .wait_o(wait_o), .irq_in(irq_in), .irq_o(irq_o),
        .fault_in(fault_in), .tmr_val(tmr_val), .loads(loads)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_tmr();
        logic [31:0] v;
        for (int k = 0; k < NT; k++) v[k*8 +: 8] = m_tmr[k];
        return v;
    endfunction

    always begin
        @(negedge clk);
        #1;
        if (cmp_en) begin
            chk("R3 tmr_val vs model", tmr_val, model_tmr());
            chk("R4 loads vs model", {24'h0, loads}, {24'h0, m_loads});
        end
    end

    task automatic wait_level(input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (wait_o !== lvl && n < 20);
    endtask

    task automatic release_strobes();
        int n;
        addr_stb_n = 1'b1;
        data_stb_n = 1'b1;
        wait_level(1'b0, n);
        chk("R2 wait fall edges", n, 3);
        write_n = 1'b1;
    endtask

    task automatic addr_cycle(input logic [7:0] a);
        int n;
        @(negedge clk);
        ad_in = a;
        addr_stb_n = 1'b0;
        wait_level(1'b1, n);
        chk("R2 wait rise edges (addr)", n, 3);
        m_addr = a;
        release_strobes();
    endtask

    task automatic apply_model(input logic [7:0] d);
        int a;
        a = int'(m_addr);
        if (a < NT) m_tmr[a] = d;
        else if (a >= 32 && a < 40) m_loads[a-32] = d[0];
        else if (a == 40) m_loads[3:0] = d[3:0];
        else if (a == 41) m_loads[7:4] = d[3:0];
    endtask

    task automatic data_write(input logic [7:0] d);
        int n;
        @(negedge clk);
        ad_in = d;
        write_n = 1'b0;
        data_stb_n = 1'b0;
        #1;
        chk("R7 no drive on write", {31'h0, ad_oe}, 32'h0);
        wait_level(1'b1, n);
        chk("R2 wait rise edges (write)", n, 3);
        apply_model(d);
        release_strobes();
    endtask

    task automatic data_read(input logic [7:0] exp, input string tag);
        int n;
        @(negedge clk);
        write_n = 1'b1;
        data_stb_n = 1'b0;
        #1;
        chk("R7 drive on read", {31'h0, ad_oe}, 32'h1);
        wait_level(1'b1, n);
        chk("R2 wait rise edges (read)", n, 3);
        chk(tag, {24'h0, ad_out}, {24'h0, exp});
        addr_stb_n = 1'b1;
        data_stb_n = 1'b1;
        #1;
        chk("R7 drive released", {31'h0, ad_oe}, 32'h0);
        wait_level(1'b0, n);
        chk("R2 wait fall edges", n, 3);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr_cycle(a);
        data_write(d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        addr_cycle(a);
        data_read(exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < NT; k++) m_tmr[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R2 reset wait", {31'h0, wait_o}, 32'h0);
        chk("R3 reset tmr", tmr_val, 32'h0);
        chk("R4 reset loads", {24'h0, loads}, 32'h0);
        chk("R10 reset irq", {31'h0, irq_o}, 32'h0);
        chk("R7 reset oe", {31'h0, ad_oe}, 32'h0);
        cmp_en = 1'b1;

        // R3 timer registers
        wr(8'h00, 8'h11);
        wr(8'h01, 8'hA5);
        wr(8'h02, 8'h3C);
        wr(8'h03, 8'hFF);
        rd(8'h02, 8'h3C, "R3 read tmr2");
        rd(8'h00, 8'h11, "R3 read tmr0");

        // R1 selector persists across data cycles
        addr_cycle(8'h01);
        data_read(8'hA5, "R1 first read tmr1");
        data_read(8'hA5, "R1 second read tmr1");
        data_write(8'h5A);
        data_read(8'h5A, "R1 write-then-read tmr1");

        // R4 single load access
        wr(8'h22, 8'h01);
        wr(8'h25, 8'hFF);
        rd(8'h25, 8'h01, "R4 read load5");
        wr(8'h22, 8'hFE);
        rd(8'h22, 8'h00, "R4 read load2 cleared");

        // R5 group access
        wr(8'h28, 8'hA5);
        wr(8'h29, 8'h0C);
        rd(8'h29, 8'h0C, "R5 read high group");
        rd(8'h28, 8'h05, "R5 read low group");

        // R6 fault latch
        @(negedge clk);
        fault_in = 4'b0101;
        @(negedge clk);
        fault_in = 4'b0000;
        rd(8'h10, 8'h05, "R6 latched faults");
        wr(8'h10, 8'h01);
        rd(8'h10, 8'h04, "R6 partial clear");
        @(negedge clk);
        fault_in = 4'b0100;
        wr(8'h10, 8'h0F);
        rd(8'h10, 8'h04, "R6 set wins over clear");
        @(negedge clk);
        fault_in = 4'b0000;
        wr(8'h10, 8'h0F);
        rd(8'h10, 8'h00, "R6 cleared after release");

        // R8 unmapped selectors
        wr(8'h40, 8'h77);
        wr(8'h2A, 8'h77);
        wr(8'h04, 8'h77);
        rd(8'h40, 8'h00, "R8 read unmapped 0x40");
        rd(8'h11, 8'h00, "R8 read unmapped 0x11");
        rd(8'h03, 8'hFF, "R8 tmr3 untouched");

        // R10 interrupt path
        @(negedge clk);
        irq_in = 1'b1;
        #1;
        chk("R10 irq not yet", {31'h0, irq_o}, 32'h0);
        @(negedge clk);
        #1;
        chk("R10 irq set", {31'h0, irq_o}, 32'h1);
        irq_in = 1'b0;
        @(negedge clk);
        #1;
        chk("R10 irq cleared", {31'h0, irq_o}, 32'h0);

        // R9 host init
        @(negedge clk);
        fault_in = 4'b0010;
        @(negedge clk);
        fault_in = 4'b0000;
        addr_cycle(8'h01);
        @(negedge clk);
        init_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        for (int k = 0; k < NT; k++) m_tmr[k] = 8'h00;
        m_loads = 8'h00;
        m_addr = 8'h00;
        @(negedge clk);
        chk("R9 init tmr", tmr_val, 32'h0);
        chk("R9 init loads", {24'h0, loads}, 32'h0);
        init_n = 1'b1;
        repeat (4) @(negedge clk);
        data_read(8'h00, "R9 selector cleared to tmr0");
        rd(8'h10, 8'h00, "R9 fault latch cleared");
        wr(8'h02, 8'h9C);
        rd(8'h02, 8'h9C, "R9 writes work after init");

        cmp_en = 1'b0;
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule